// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block chooses where each of the two ALU operands of a five-stage load/store pipeline comes from. It takes the two source register numbers of the instruction now in execute, and the destination register number and write-enable of the instructions one and two places ahead of it (in the memory and write-back stages). From these it builds a 2-bit select per operand. The select either keeps the value read from the register file in decode, or takes the newer result still in flight from the memory stage or the write-back stage. The block applies its own selects to a pair of operand multiplexers, so the forwarded operand values are available at its outputs.

A second, smaller path covers the register file read in decode. When write-back is writing a register in the same cycle that decode reads it, the decode read returns the value being written and not the stale stored word. The block has no clock and no state. Every output is a function of the present inputs. The register storage, the ALU and stall generation are outside the block.

Top module: `fwd_unit`

## Requirements
- R1: When memRegWrite is 1, memRdIdx is nonzero and memRdIdx equals exRsIdx, forwardA is 2'b10.
- R2: When memRegWrite is 1, memRdIdx is nonzero and memRdIdx equals exRtIdx, forwardB is 2'b10.
- R3: When wbRegWrite is 1, wbRdIdx is nonzero and wbRdIdx equals exRsIdx, and R1 does not apply, forwardA is 2'b01.
- R4: When wbRegWrite is 1, wbRdIdx is nonzero and wbRdIdx equals exRtIdx, and R2 does not apply, forwardB is 2'b01.
- R5: A destination index of 0 never causes forwarding, whatever the write-enable: no select becomes 2'b10 or 2'b01 because of it, and the decode read of register 0 is never bypassed.
- R6: When the memory-stage and write-back-stage destinations both match the same source, the select is 2'b10, because the memory-stage value is the newer one.
- R7: When no stage matches a source, its select is 2'b00.
- R8: operandA and operandB follow their selects: 2'b00 gives exRegA or exRegB, 2'b01 gives wbResult, and 2'b10 gives memResult.
- R9: All outputs are combinational. A change on any input shows on the outputs in the same cycle, with no clock edge needed.
- R10: When wbRegWrite is 1, wbRdIdx is nonzero and wbRdIdx equals decRsIdx (or decRtIdx), decDataA (or decDataB) equals wbResult. Otherwise it equals rfReadA (or rfReadB).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| exRsIdx | input | 5 | First source register number of the execute-stage instruction |
| exRtIdx | input | 5 | Second source register number of the execute-stage instruction |
| memRdIdx | input | 5 | Destination register number of the memory-stage instruction |
| memRegWrite | input | 1 | Memory-stage instruction writes its destination |
| wbRdIdx | input | 5 | Destination register number of the write-back-stage instruction |
| wbRegWrite | input | 1 | Write-back-stage instruction writes its destination |
| exRegA | input | 32 | First operand as read from the register file in decode |
| exRegB | input | 32 | Second operand as read from the register file in decode |
| memResult | input | 32 | Result held in the memory stage |
| wbResult | input | 32 | Value being written back |
| decRsIdx | input | 5 | First register number read in decode |
| decRtIdx | input | 5 | Second register number read in decode |
| rfReadA | input | 32 | Stored register file word for decRsIdx |
| rfReadB | input | 32 | Stored register file word for decRtIdx |
| forwardA | output | 2 | Source select for the first ALU operand |
| forwardB | output | 2 | Source select for the second ALU operand |
| operandA | output | 32 | First ALU operand after the bypass multiplexer |
| operandB | output | 32 | Second ALU operand after the bypass multiplexer |
| decDataA | output | 32 | Decode read of the first register with write-through |
| decDataB | output | 32 | Decode read of the second register with write-through |

## Verification
Every result of this block is due in the same cycle as the input that causes it, because no register lies between any input and any output. The bench changes the inputs just after a rising clock edge and reads the selects, operands and decode data at the next falling edge. Half a period passes between driving and sampling, and no edge at which a flop could capture lies in that window. No check waits for a later cycle, so a design that put a register on any path would be caught by the R9 checks.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  localparam int NUM_OPS = 2;

  typedef enum logic [1:0] {
    SEL_REGFILE = 2'b00,
    SEL_WB      = 2'b01,
    SEL_MEM     = 2'b10
  } fwdSel_t;

  typedef struct packed {
    fwdSel_t [NUM_OPS-1:0] sel;
    logic    [NUM_OPS-1:0] decBypass;
  } fwdStrobes_t;

endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
  parameter int IDX_W = 5
) (
  input  logic [IDX_W-1:0] srcIdx,
  input  logic [IDX_W-1:0] dstIdx,
  input  logic             dstWrite,
  output logic             hit
);

  logic dstLive;

  // Register zero is hardwired and must never be treated as a producer.
  assign dstLive = dstWrite && (dstIdx != '0);
  assign hit     = dstLive && (dstIdx == srcIdx);

endmodule

// File: rtl/fwd_control.sv
module fwd_control
  import fwd_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic [NUM_OPS-1:0][IDX_W-1:0] exSrc,
  input  logic [NUM_OPS-1:0][IDX_W-1:0] decSrc,
  input  logic [IDX_W-1:0]              memRd,
  input  logic                          memWe,
  input  logic [IDX_W-1:0]              wbRd,
  input  logic                          wbWe,
  output fwdStrobes_t                   strobes
);

  fwdSel_t [NUM_OPS-1:0] selVec;
  logic    [NUM_OPS-1:0] decVec;

  generate
    for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
      logic memHit;
      logic wbHit;
      logic decHit;

      fwd_match #(.IDX_W(IDX_W)) u_memMatch (
        .srcIdx(exSrc[i]), .dstIdx(memRd), .dstWrite(memWe), .hit(memHit)
      );
      fwd_match #(.IDX_W(IDX_W)) u_wbMatch (
        .srcIdx(exSrc[i]), .dstIdx(wbRd), .dstWrite(wbWe), .hit(wbHit)
      );
      fwd_match #(.IDX_W(IDX_W)) u_decMatch (
        .srcIdx(decSrc[i]), .dstIdx(wbRd), .dstWrite(wbWe), .hit(decHit)
      );

      // The nearer stage holds the younger value, so it is tested first.
      assign selVec[i] = memHit ? SEL_MEM : (wbHit ? SEL_WB : SEL_REGFILE);
      assign decVec[i] = decHit;
    end
  endgenerate

  assign strobes.sel       = selVec;
  assign strobes.decBypass = decVec;

endmodule

// File: rtl/fwd_datapath.sv
module fwd_datapath
  import fwd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  fwdStrobes_t                    strobes,
  input  logic [NUM_OPS-1:0][DATA_W-1:0] exReg,
  input  logic [NUM_OPS-1:0][DATA_W-1:0] rfRead,
  input  logic [DATA_W-1:0]              memResult,
  input  logic [DATA_W-1:0]              wbResult,
  output logic [NUM_OPS-1:0][DATA_W-1:0] operand,
  output logic [NUM_OPS-1:0][DATA_W-1:0] decData
);

  generate
    for (genvar i = 0; i < NUM_OPS; i++) begin : g_mux
      logic [DATA_W-1:0] opVal;

      always_comb begin
        unique case (strobes.sel[i])
          SEL_MEM: opVal = memResult;
          SEL_WB:  opVal = wbResult;
          default: opVal = exReg[i];
        endcase
      end

      assign operand[i] = opVal;
      assign decData[i] = strobes.decBypass[i] ? wbResult : rfRead[i];
    end
  endgenerate

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int IDX_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic [IDX_W-1:0]  exRsIdx,
  input  logic [IDX_W-1:0]  exRtIdx,
  input  logic [IDX_W-1:0]  memRdIdx,
  input  logic              memRegWrite,
  input  logic [IDX_W-1:0]  wbRdIdx,
  input  logic              wbRegWrite,
  input  logic [DATA_W-1:0] exRegA,
  input  logic [DATA_W-1:0] exRegB,
  input  logic [DATA_W-1:0] memResult,
  input  logic [DATA_W-1:0] wbResult,
  input  logic [IDX_W-1:0]  decRsIdx,
  input  logic [IDX_W-1:0]  decRtIdx,
  input  logic [DATA_W-1:0] rfReadA,
  input  logic [DATA_W-1:0] rfReadB,
  output logic [1:0]        forwardA,
  output logic [1:0]        forwardB,
  output logic [DATA_W-1:0] operandA,
  output logic [DATA_W-1:0] operandB,
  output logic [DATA_W-1:0] decDataA,
  output logic [DATA_W-1:0] decDataB
);

  fwdStrobes_t                    strobes;
  logic [NUM_OPS-1:0][DATA_W-1:0] operandVec;
  logic [NUM_OPS-1:0][DATA_W-1:0] decVec;

  fwd_control #(.IDX_W(IDX_W)) u_control (
    .exSrc  ({exRtIdx, exRsIdx}),
    .decSrc ({decRtIdx, decRsIdx}),
    .memRd  (memRdIdx),
    .memWe  (memRegWrite),
    .wbRd   (wbRdIdx),
    .wbWe   (wbRegWrite),
    .strobes(strobes)
  );

  fwd_datapath #(.DATA_W(DATA_W)) u_datapath (
    .strobes  (strobes),
    .exReg    ({exRegB, exRegA}),
    .rfRead   ({rfReadB, rfReadA}),
    .memResult(memResult),
    .wbResult (wbResult),
    .operand  (operandVec),
    .decData  (decVec)
  );

  assign forwardA = strobes.sel[0];
  assign forwardB = strobes.sel[1];
  assign operandA = operandVec[0];
  assign operandB = operandVec[1];
  assign decDataA = decVec[0];
  assign decDataB = decVec[1];

endmodule

// File: rtl/fwd_unit_checker.sv
module fwd_unit_checker #(
  parameter int IDX_W  = 5,
  parameter int DATA_W = 32
) (
  input logic [IDX_W-1:0]  exRsIdx,
  input logic [IDX_W-1:0]  exRtIdx,
  input logic [IDX_W-1:0]  memRdIdx,
  input logic              memRegWrite,
  input logic [IDX_W-1:0]  wbRdIdx,
  input logic              wbRegWrite,
  input logic [DATA_W-1:0] exRegA,
  input logic [DATA_W-1:0] exRegB,
  input logic [DATA_W-1:0] memResult,
  input logic [DATA_W-1:0] wbResult,
  input logic [IDX_W-1:0]  decRsIdx,
  input logic [IDX_W-1:0]  decRtIdx,
  input logic [DATA_W-1:0] rfReadA,
  input logic [DATA_W-1:0] rfReadB,
  input logic [1:0]        forwardA,
  input logic [1:0]        forwardB,
  input logic [DATA_W-1:0] operandA,
  input logic [DATA_W-1:0] operandB,
  input logic [DATA_W-1:0] decDataA,
  input logic [DATA_W-1:0] decDataB
);

  logic known;
  assign known = !$isunknown({exRsIdx, exRtIdx, memRdIdx, memRegWrite, wbRdIdx,
                              wbRegWrite, exRegA, exRegB, memResult, wbResult,
                              decRsIdx, decRtIdx, rfReadA, rfReadB, forwardA,
                              forwardB, operandA, operandB, decDataA, decDataB});

  always_comb begin
    if (known) begin
      if (memRegWrite && memRdIdx != '0 && memRdIdx == exRsIdx)
        a_r1_mem_to_a: assert (forwardA == 2'b10) else $error("R1 forwardA");
      if (memRegWrite && memRdIdx != '0 && memRdIdx == exRtIdx)
        a_r2_mem_to_b: assert (forwardB == 2'b10) else $error("R2 forwardB");
      if (forwardA == 2'b01)
        a_r3_wb_to_a: assert (wbRegWrite && wbRdIdx == exRsIdx) else $error("R3 forwardA");
      if (forwardB == 2'b01)
        a_r4_wb_to_b: assert (wbRegWrite && wbRdIdx == exRtIdx) else $error("R4 forwardB");
      if (forwardA != 2'b00)
        a_r5_zero_a: assert (exRsIdx != '0) else $error("R5 forwardA");
      if (forwardB != 2'b00)
        a_r5_zero_b: assert (exRtIdx != '0) else $error("R5 forwardB");
      if (decRsIdx == '0)
        a_r5_zero_dec: assert (decDataA == rfReadA) else $error("R5 decDataA");
      a_r7_legal_a: assert (forwardA != 2'b11) else $error("R7 forwardA");
      a_r7_legal_b: assert (forwardB != 2'b11) else $error("R7 forwardB");
      if (forwardA == 2'b10)
        a_r8_op_a_mem: assert (operandA == memResult) else $error("R8 operandA");
      if (forwardB == 2'b00)
        a_r8_op_b_reg: assert (operandB == exRegB) else $error("R8 operandB");
      if (wbRegWrite && wbRdIdx != '0 && wbRdIdx == decRtIdx)
        a_r10_dec_b: assert (decDataB == wbResult) else $error("R10 decDataB");
    end
  end

endmodule

bind fwd_unit fwd_unit_checker #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_fwdChecker (.*);

// File: tb/tb_fwd_unit.sv
module tb_fwd_unit;

  localparam int CLK_PERIOD = 10;
  localparam int IDX_W      = 5;
  localparam int DATA_W     = 32;
  localparam int RAND_ITERS = 3000;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [IDX_W-1:0]  exRsIdx, exRtIdx, memRdIdx, wbRdIdx, decRsIdx, decRtIdx;
  logic              memRegWrite, wbRegWrite;
  logic [DATA_W-1:0] exRegA, exRegB, memResult, wbResult, rfReadA, rfReadB;
  logic [1:0]        forwardA, forwardB;
  logic [DATA_W-1:0] operandA, operandB, decDataA, decDataB;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  fwd_unit #(.IDX_W(IDX_W), .DATA_W(DATA_W)) dut (.*);

  function automatic logic [1:0] expSel(input logic [IDX_W-1:0] src,
                                        input logic [IDX_W-1:0] mRd, input logic mWe,
                                        input logic [IDX_W-1:0] wRd, input logic wWe);
    if (mWe && mRd != 0 && mRd == src) return 2'b10;
    if (wWe && wRd != 0 && wRd == src) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [DATA_W-1:0] expOp(input logic [1:0] sel,
                                              input logic [DATA_W-1:0] reg_v);
    if (sel == 2'b10) return memResult;
    if (sel == 2'b01) return wbResult;
    return reg_v;
  endfunction

  function automatic logic [DATA_W-1:0] expDec(input logic [IDX_W-1:0] src,
                                               input logic [DATA_W-1:0] raw);
    if (wbRegWrite && wbRdIdx != 0 && wbRdIdx == src) return wbResult;
    return raw;
  endfunction

  task automatic chk(input string req, input logic [DATA_W-1:0] act,
                     input logic [DATA_W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    logic [1:0] eA, eB;
    eA = expSel(exRsIdx, memRdIdx, memRegWrite, wbRdIdx, wbRegWrite);
    eB = expSel(exRtIdx, memRdIdx, memRegWrite, wbRdIdx, wbRegWrite);
    chk({tag, " forwardA"}, DATA_W'(forwardA), DATA_W'(eA));
    chk({tag, " forwardB"}, DATA_W'(forwardB), DATA_W'(eB));
    chk({tag, " R8 operandA"}, operandA, expOp(eA, exRegA));
    chk({tag, " R8 operandB"}, operandB, expOp(eB, exRegB));
    chk({tag, " R10 decDataA"}, decDataA, expDec(decRsIdx, rfReadA));
    chk({tag, " R10 decDataB"}, decDataB, expDec(decRtIdx, rfReadB));
  endtask

  task automatic drive(input logic [IDX_W-1:0] rs, input logic [IDX_W-1:0] rt,
                       input logic [IDX_W-1:0] mRd, input logic mWe,
                       input logic [IDX_W-1:0] wRd, input logic wWe);
    @(posedge clk);
    #1;
    exRsIdx = rs; exRtIdx = rt; memRdIdx = mRd; memRegWrite = mWe;
    wbRdIdx = wRd; wbRegWrite = wWe;
    @(negedge clk);
  endtask

  initial begin
    exRsIdx = 0; exRtIdx = 0; memRdIdx = 0; memRegWrite = 0;
    wbRdIdx = 0; wbRegWrite = 0; decRsIdx = 0; decRtIdx = 0;
    exRegA = 32'hA0A0_0001; exRegB = 32'hB0B0_0002;
    memResult = 32'hCAFE_0003; wbResult = 32'hD00D_0004;
    rfReadA = 32'h1111_0005; rfReadB = 32'h2222_0006;
    void'($urandom(32'd20240611));
    @(negedge clk);
    // Quiet state: nothing writes, every select idle (R7).
    checkAll("R7 quiet");
    chk("R7 forwardA idle", DATA_W'(forwardA), 0);

    drive(5'd3, 5'd9, 5'd3, 1'b1, 5'd0, 1'b0);
    chk("R1 mem to A", DATA_W'(forwardA), 2);
    chk("R8 operandA mem", operandA, memResult);
    drive(5'd4, 5'd7, 5'd7, 1'b1, 5'd0, 1'b0);
    chk("R2 mem to B", DATA_W'(forwardB), 2);
    drive(5'd12, 5'd1, 5'd0, 1'b0, 5'd12, 1'b1);
    chk("R3 wb to A", DATA_W'(forwardA), 1);
    chk("R8 operandA wb", operandA, wbResult);
    drive(5'd2, 5'd30, 5'd0, 1'b0, 5'd30, 1'b1);
    chk("R4 wb to B", DATA_W'(forwardB), 1);
    drive(5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1);
    chk("R5 zero A", DATA_W'(forwardA), 0);
    chk("R5 zero B", DATA_W'(forwardB), 0);
    chk("R5 operandA reg", operandA, exRegA);
    drive(5'd6, 5'd6, 5'd6, 1'b1, 5'd6, 1'b1);
    chk("R6 priority A", DATA_W'(forwardA), 2);
    chk("R6 priority B", DATA_W'(forwardB), 2);
    drive(5'd6, 5'd5, 5'd6, 1'b0, 5'd5, 1'b0);
    chk("R7 no write", DATA_W'(forwardA), 0);
    chk("R7 no write B", DATA_W'(forwardB), 0);

    // Decode write-through and its zero exclusion (R10, R5).
    #1; wbRegWrite = 1; wbRdIdx = 5'd17; decRsIdx = 5'd17; decRtIdx = 5'd16;
    @(negedge clk);
    chk("R10 decDataA bypass", decDataA, wbResult);
    chk("R10 decDataB stored", decDataB, rfReadB);
    @(posedge clk); #1; wbRdIdx = 5'd0; decRsIdx = 5'd0;
    @(negedge clk);
    chk("R5 dec zero", decDataA, rfReadA);

    // Same-cycle response: change an input between edges (R9).
    #1; memRdIdx = 5'd9; memRegWrite = 1; exRsIdx = 5'd9;
    #1;
    chk("R9 combinational A", DATA_W'(forwardA), 2);
    memResult = 32'h5555_AAAA;
    #1;
    chk("R9 combinational operand", operandA, 32'h5555_AAAA);

    for (int it = 0; it < RAND_ITERS; it++) begin
      @(posedge clk);
      #1;
      exRsIdx = IDX_W'($urandom % 6); exRtIdx = IDX_W'($urandom % 6);
      memRdIdx = IDX_W'($urandom % 6); wbRdIdx = IDX_W'($urandom % 6);
      decRsIdx = IDX_W'($urandom % 6); decRtIdx = IDX_W'($urandom % 6);
      memRegWrite = 1'($urandom); wbRegWrite = 1'($urandom);
      exRegA = $urandom; exRegB = $urandom; memResult = $urandom;
      wbResult = $urandom; rfReadA = $urandom; rfReadB = $urandom;
      @(negedge clk);
      checkAll("R1 R2 R3 R4 R5 R6 random");
    end
    done = 1'b1;
  end

  always @(posedge clk) begin
    cycles++;
    if (done) begin
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end else if (cycles > WATCHDOG) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule